// File: doc/BRIEF.md
# TLB Virtual Page Search Unit

This block looks up a virtual page number in a fully associative translation table of 64 entries. Software loads the entries through a simple write port (entry number, valid flag, page number, page-size code). It starts a lookup by writing a 32-bit search word. The upper 22 bits of that word hold the page number, and the low 10 bits are reserved.

In the cycle after the write, the stored key is compared against every valid entry at once. Each entry's own page-size code decides how many low-order page-number bits are left out of its compare. The lowest-numbered matching entry wins. The outcome is written into a 32-bit index register. A hit stores the entry number and clears the miss flag. A miss sets the miss flag and keeps the previous entry number. A done pulse marks the cycle in which the lookup resolves, and the index register shows the result from the following cycle.

Top module: `tlbs_search_unit`

## Requirements
- R1: After reset, `done_o` is 0, `index_o` reads 0x0000_0000, and every table entry is invalid.
- R2: A cycle with `srch_we`=1 makes `done_o` equal 1 in the next cycle. `done_o` is 0 in a cycle that does not follow a search write.
- R3: The search key is `srch_data[31:10]`, which is big-endian bits 0 to 21. Bits `srch_data[9:0]` are reserved and have no effect on the outcome.
- R4: An entry whose valid flag is 0 never matches, whatever its page number.
- R5: An entry with size code s (0..7, page size 1 KB·4^s) leaves the low 2·s bits of the page number out of its compare.
- R6: On a hit, `index_o` becomes {bit31=0, bits 30:6 = 0, bits 5:0 = entry number}. The new value is visible in the cycle after the `done_o` cycle.
- R7: On a miss, bit 31 of `index_o` (MISS) becomes 1 and bits 5:0 keep their previous value.
- R8: When several valid entries match, the lowest entry number is reported.
- R9: `ent_we`=1 writes {valid, vpn, size} into entry `ent_idx` at the clock edge. A load presented during a `done_o` cycle does not affect the lookup resolving in that cycle; it only affects later lookups.
- R10: Search writes in consecutive cycles each resolve in turn. The index register shows the first result and then the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ent_we | input | 1 | Entry load strobe |
| ent_idx | input | 6 | Entry number to load |
| ent_valid | input | 1 | Valid flag for the loaded entry |
| ent_vpn | input | 22 | Page number for the loaded entry |
| ent_size | input | 3 | Page-size code for the loaded entry |
| srch_we | input | 1 | Search register write strobe |
| srch_data | input | 32 | Search word; page number in bits 31:10 |
| done_o | output | 1 | High in the cycle a lookup resolves |
| index_o | output | 32 | Index register: MISS in bit 31, entry number in bits 5:0 |

## Verification
The assertions assume that `ent_idx` always names an existing entry, that inputs are held stable around each rising edge, and that reset is held for at least one edge before any check is meaningful. The bench drives every input on the falling edge and keeps `ent_idx` within 0 to 63. It issues search writes both in isolation and back to back, so the done and index properties are exercised under the only two spacings the unit distinguishes. Entry loads are placed in the resolving cycle on purpose, to probe the ordering that R9 describes.

// File: rtl/tlbs_pkg.sv
package tlbs_pkg;

    parameter int NUM_ENTRIES = 64;
    parameter int VPN_W       = 22;
    parameter int SIZE_W      = 3;
    parameter int REG_W       = 32;
    parameter int SIZE_STEP   = 2;   // page size grows by 4x per code step

    localparam int IDX_W  = $clog2(NUM_ENTRIES);
    localparam int RSVD_W = REG_W - VPN_W;
    localparam int MISS_BIT = REG_W - 1;

    typedef logic [VPN_W-1:0]  vpn_t;
    typedef logic [SIZE_W-1:0] size_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef struct packed {
        logic  valid;
        vpn_t  vpn;
        size_t size;
    } entry_t;

    typedef struct packed {
        logic hit;
        idx_t idx;
    } pick_t;

    // Bits of the page number that take part in the compare for a size code.
    function automatic vpn_t vpn_mask(size_t sz);
        vpn_t m;
        m = {VPN_W{1'b1}};
        m = m << (SIZE_STEP * int'(sz));
        return m;
    endfunction

endpackage

// File: rtl/tlbs_table.sv
module tlbs_table
    import tlbs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_en,
    input  idx_t   wr_idx,
    input  entry_t wr_entry,
    output entry_t tbl_o [NUM_ENTRIES]
);

    entry_t mem_q [NUM_ENTRIES];

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                mem_q[g] <= '0;
            end else if (wr_en && (wr_idx == idx_t'(g))) begin
                mem_q[g] <= wr_entry;
            end
        end
        assign tbl_o[g] = mem_q[g];
    end

endmodule

// File: rtl/tlbs_match.sv
module tlbs_match
    import tlbs_pkg::*;
(
    input  entry_t                 tbl_i [NUM_ENTRIES],
    input  vpn_t                   key_i,
    output logic [NUM_ENTRIES-1:0] match_o
);

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
        vpn_t diff;
        assign diff       = (tbl_i[g].vpn ^ key_i) & vpn_mask(tbl_i[g].size);
        assign match_o[g] = tbl_i[g].valid && (diff == '0);
    end

endmodule

// File: rtl/tlbs_prio.sv
module tlbs_prio
    import tlbs_pkg::*;
(
    input  logic [NUM_ENTRIES-1:0] match_i,
    output pick_t                  pick_o
);

    always_comb begin
        pick_o = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (match_i[i]) begin
                pick_o.hit = 1'b1;
                pick_o.idx = idx_t'(i);
            end
        end
    end

endmodule

// File: rtl/tlbs_search_unit.sv
module tlbs_search_unit
    import tlbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ent_we,
    input  logic [IDX_W-1:0]  ent_idx,
    input  logic              ent_valid,
    input  logic [VPN_W-1:0]  ent_vpn,
    input  logic [SIZE_W-1:0] ent_size,
    input  logic              srch_we,
    input  logic [REG_W-1:0]  srch_data,
    output logic              done_o,
    output logic [REG_W-1:0]  index_o
);

    entry_t                 tbl   [NUM_ENTRIES];
    entry_t                 wr_entry;
    logic [NUM_ENTRIES-1:0] match_vec;
    pick_t                  pick;
    vpn_t                   key_q;
    logic                   done_q;
    logic                   miss_q;
    idx_t                   idx_q;
    logic                   unused_rsvd;

    assign wr_entry    = '{valid: ent_valid, vpn: ent_vpn, size: ent_size};
    assign unused_rsvd = ^srch_data[RSVD_W-1:0];

    tlbs_table u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (ent_we),
        .wr_idx   (ent_idx),
        .wr_entry (wr_entry),
        .tbl_o    (tbl)
    );

    tlbs_match u_match (
        .tbl_i   (tbl),
        .key_i   (key_q),
        .match_o (match_vec)
    );

    tlbs_prio u_prio (
        .match_i (match_vec),
        .pick_o  (pick)
    );

    // Search register capture: the lookup resolves in the following cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            key_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= srch_we;
            if (srch_we) begin
                key_q <= srch_data[REG_W-1 -: VPN_W];
            end
        end
    end

    // Index register update.
    always_ff @(posedge clk) begin
        if (rst) begin
            miss_q <= 1'b0;
            idx_q  <= '0;
        end else if (done_q) begin
            miss_q <= ~pick.hit;
            if (pick.hit) begin
                idx_q <= pick.idx;
            end
        end
    end

    assign done_o  = done_q;
    assign index_o = {miss_q, {(REG_W-1-IDX_W){1'b0}}, idx_q};

    a_r2_done_follows_write: assert property (@(posedge clk) disable iff (rst)
        srch_we |=> done_o);

    a_r2_no_spurious_done: assert property (@(posedge clk) disable iff (rst)
        !srch_we |=> !done_o);

    a_r6_hit_reports_entry: assert property (@(posedge clk) disable iff (rst)
        (done_o && pick.hit) |=> (!index_o[MISS_BIT] && index_o[IDX_W-1:0] == $past(pick.idx)));

    a_r7_miss_keeps_index: assert property (@(posedge clk) disable iff (rst)
        (done_o && !pick.hit) |=> (index_o[MISS_BIT] && $stable(index_o[IDX_W-1:0])));

    a_r8_lowest_wins: assert property (@(posedge clk) disable iff (rst)
        pick.hit |-> (match_vec[pick.idx] &&
            $countones(match_vec & ((NUM_ENTRIES'(1) << pick.idx) - NUM_ENTRIES'(1))) == 0));

    a_r4_valid_only: assert property (@(posedge clk) disable iff (rst)
        pick.hit |-> tbl[pick.idx].valid);

    a_r6_zero_middle_bits: assert property (@(posedge clk) disable iff (rst)
        index_o[REG_W-2:IDX_W] == '0);

endmodule

// File: tb/test_tlbs_search_unit.sv
module test_tlbs_search_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ent_we = 1'b0;
    logic [5:0]  ent_idx = '0;
    logic        ent_valid = 1'b0;
    logic [21:0] ent_vpn = '0;
    logic [2:0]  ent_size = '0;
    logic        srch_we = 1'b0;
    logic [31:0] srch_data = '0;
    logic        done_o;
    logic [31:0] index_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    bit running = 0;

    always #5 clk = ~clk;

    tlbs_search_unit i_tlbs_search_unit (
        .clk(clk), .rst(rst), .ent_we(ent_we), .ent_idx(ent_idx),
        .ent_valid(ent_valid), .ent_vpn(ent_vpn), .ent_size(ent_size),
        .srch_we(srch_we), .srch_data(srch_data),
        .done_o(done_o), .index_o(index_o)
    );

    // Behavioural reference model
    bit          m_valid [64];
    int          m_vpn   [64];
    int          m_size  [64];
    bit          m_done;
    int          m_key;
    logic [31:0] m_index;

    function automatic int lookup(int key);
        for (int i = 0; i < 64; i++) begin
            int mask;
            mask = 32'h003F_FFFF & ~((1 << (2 * m_size[i])) - 1);
            if (m_valid[i] && (((m_vpn[i] ^ key) & mask) == 0)) return i;
        end
        return -1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 64; i++) begin
                m_valid[i] = 0; m_vpn[i] = 0; m_size[i] = 0;
            end
            m_done = 0; m_key = 0; m_index = 32'h0;
        end else begin
            if (m_done) begin
                int r;
                r = lookup(m_key);
                if (r >= 0) m_index = r;
                else m_index[31] = 1'b1;
            end
            m_done = srch_we;
            if (srch_we) m_key = int'(srch_data[31:10]);
            if (ent_we) begin
                m_valid[ent_idx] = ent_valid;
                m_vpn[ent_idx]   = int'(ent_vpn);
                m_size[ent_idx]  = int'(ent_size);
            end
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (running && !rst) begin
            check("R2 done vs model", {31'b0, done_o}, {31'b0, m_done});
            check("R6 index vs model", index_o, m_index);
        end
    end

    task automatic load(int idx, bit v, int vpn, int sz);
        ent_we = 1; ent_idx = 6'(idx); ent_valid = v; ent_vpn = 22'(vpn); ent_size = 3'(sz);
        @(negedge clk);
        ent_we = 0;
    endtask

    task automatic search(int vpn, int rsvd, logic [31:0] exp, string tag);
        srch_we = 1; srch_data = {22'(vpn), 10'(rsvd)};
        @(negedge clk);
        srch_we = 0;
        check({tag, " done pulse"}, {31'b0, done_o}, 32'h1);
        @(negedge clk);
        check(tag, index_o, exp);
        check({tag, " done drops"}, {31'b0, done_o}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset done", {31'b0, done_o}, 32'h0);
        check("R1 reset index", index_o, 32'h0);
        rst = 0;
        running = 1;
        @(negedge clk);
        check("R2 idle no done", {31'b0, done_o}, 32'h0);

        search(22'h00000, 0, 32'h8000_0000, "R1 empty table misses");

        load(5, 1, 22'h12345, 0);
        search(22'h12345, 10'h3FF, 32'h0000_0005, "R3 reserved bits ignored hit");
        search(22'h12346, 0, 32'h8000_0005, "R7 miss keeps index");

        load(9, 1, 22'h20000, 7);
        search(22'h23FFF, 10'h155, 32'h0000_0009, "R5 size 16M masks 14 bits");
        load(10, 1, 22'h30000, 1);
        search(22'h30003, 0, 32'h0000_000A, "R5 size 4K masks 2 bits");
        search(22'h30004, 0, 32'h8000_000A, "R5 size 4K upper bit compared");

        load(2, 0, 22'h00ABC, 0);
        load(20, 1, 22'h00ABC, 0);
        load(3, 1, 22'h00ABC, 0);
        search(22'h00ABC, 0, 32'h0000_0003, "R8 lowest match wins, R4 invalid skipped");
        load(3, 0, 22'h00ABC, 0);
        search(22'h00ABC, 0, 32'h0000_0014, "R4 invalidated entry ignored");

        // R9: load in the resolving cycle does not affect that lookup
        srch_we = 1; srch_data = {22'h11111, 10'h0};
        @(negedge clk);
        srch_we = 0;
        ent_we = 1; ent_idx = 6'd0; ent_valid = 1; ent_vpn = 22'h11111; ent_size = 0;
        check("R9 done during load", {31'b0, done_o}, 32'h1);
        @(negedge clk);
        ent_we = 0;
        check("R9 load after search", index_o, 32'h8000_0014);
        search(22'h11111, 0, 32'h0000_0000, "R9 loaded entry used later");

        // R10: back-to-back searches
        srch_we = 1; srch_data = {22'h12345, 10'h0};
        @(negedge clk);
        srch_data = {22'h20001, 10'h0};
        check("R10 first done", {31'b0, done_o}, 32'h1);
        @(negedge clk);
        srch_we = 0;
        check("R10 first result", index_o, 32'h0000_0005);
        check("R10 second done", {31'b0, done_o}, 32'h1);
        @(negedge clk);
        check("R10 second result", index_o, 32'h0000_0009);

        repeat (3) @(negedge clk);
        running = 0;
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule